// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block produces the two DMA request lines of a UART whose receive and transmit FIFOs each hold 64 bytes. It watches the FIFO fill levels and the strobes with which the DMA engine drains the receive FIFO or fills the transmit FIFO. Each request stays up until the DMA has moved exactly one programmed burst. This lets an external DMA engine work in fixed-size bursts without overrunning the transmit FIFO or leaving bytes behind in the receive FIFO.

The burst size for each direction comes from a small decoder. A 2-bit selector can pick one of four preset sizes. In fine mode, the selector is joined below a 4-bit high field to give any size from 1 to 63.

The transmit side normally refills as soon as the FIFO has room for a whole burst. An optional low-water mode instead waits until transmission drains the FIFO down to a 6-bit threshold. The block falls back to the room-based rule when the threshold plus the burst would not fit in the FIFO. A synchronous active-high reset and a DMA enable input both force the requests low and discard any burst in progress.

Top module: `uart_dma_req_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `rx_req` and `tx_req` are low after that edge, whatever the levels are.
- R2: With `rx_req` low and `dma_en` high, `rx_req` rises at the first clock edge that samples `rx_level` at or above the RX burst size. It stays low while `rx_level` is one below the burst size.
- R3: Once `rx_req` is high, it stays high until the burst-size-th `rx_pop` has been sampled, and it is low after that edge.
- R4: `rx_pop` strobes sampled while `rx_req` is low are ignored. They do not shorten the next burst.
- R5: In room-based mode, `tx_req` rises one edge after the sampled free space (64 minus `tx_level`) is at least the TX burst size. This includes an empty FIFO. It stays low when the free space is one short.
- R6: Once `tx_req` is high, it stays high until exactly the burst size of `tx_push` strobes has been sampled. A shorter run of writes leaves it high.
- R7: Burst size decoding works as follows. With the fine bit at 0, selector values 0, 1, 2 and 3 give 8, 16, 32 and 56. With the fine bit at 1, the size is {hi[3:0], sel[1:0]}, and a value of 0 gives 1.
- R8: With `tx_thr_mode` set and `tx_thr` plus the TX burst size at most 64, `tx_req` rises one edge after `tx_level` is sampled at or below `tx_thr`. It then asks for one TX burst.
- R9: When `tx_thr` plus the TX burst size exceeds 64, the threshold mode bit is ignored and the rule of R5 applies.
- R10: `dma_en` low at an edge forces both requests low after it and discards the partial burst count. After re-enabling, a full burst is required.
- R11: The burst size is captured when a request rises. Changing the size fields during a burst does not change how many strobes end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Enables both request lines |
| rx_level | input | 7 | RX FIFO occupancy, 0..64 |
| rx_pop | input | 1 | One byte read from RX FIFO by DMA |
| rx_fine | input | 1 | RX burst decode: 1 = fine, 0 = preset |
| rx_sel | input | 2 | RX burst selector / low bits |
| rx_hi | input | 4 | RX burst high bits (fine mode) |
| tx_level | input | 7 | TX FIFO occupancy, 0..64 |
| tx_push | input | 1 | One byte written to TX FIFO by DMA |
| tx_fine | input | 1 | TX burst decode: 1 = fine, 0 = preset |
| tx_sel | input | 2 | TX burst selector / low bits |
| tx_hi | input | 4 | TX burst high bits (fine mode) |
| tx_thr_mode | input | 1 | Select low-water TX trigger |
| tx_thr | input | 6 | TX low-water threshold |
| rx_req | output | 1 | RX DMA request |
| tx_req | output | 1 | TX DMA request |

## Verification
The bench sweeps all 68 burst-size encodings on both directions. It probes the level one short of the trigger point and then exactly at it. A design with an off-by-one compare would assert early or late there, and a wrong decode would release after the wrong strobe count. Stray reads before a burst and a dropped enable mid-burst catch a counter that is not cleared at the start of a request. A size change mid-burst catches a design that compares against the live fields. All 64 threshold values are swept with burst 8, which exposes a fallback test placed at the wrong side of the capacity limit: it would either allow overrun or never refill.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int FIELD_W    = 6;

  // Coarse burst presets selected by the 2-bit field
  function automatic logic [FIELD_W-1:0] preset_burst(input logic [1:0] sel);
    logic [FIELD_W-1:0] v;
    case (sel)
      2'd0:    v = 6'd8;
      2'd1:    v = 6'd16;
      2'd2:    v = 6'd32;
      default: v = 6'd56;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/uart_dma_trig_dec.sv
module uart_dma_trig_dec #(
  parameter int CW = 7
) (
  input  logic          fine,
  input  logic [1:0]    sel,
  input  logic [3:0]    hi,
  output logic [CW-1:0] burst
);
  import uart_dma_pkg::*;

  logic [FIELD_W-1:0] raw;

  always_comb begin
    raw = fine ? {hi, sel} : preset_burst(sel);
    if (raw == '0) burst = {{(CW-1){1'b0}}, 1'b1};
    else           burst = {{(CW-FIELD_W){1'b0}}, raw};
  end
endmodule

// File: rtl/uart_dma_burst.sv
module uart_dma_burst #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic          strobe,
  input  logic [CW-1:0] size,
  output logic          req
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] size_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req    <= 1'b0;
      cnt_q  <= '0;
      size_q <= {{(CW-1){1'b0}}, 1'b1};
    end else if (!req) begin
      if (start) begin
        req    <= 1'b1;
        cnt_q  <= '0;
        size_q <= size;
      end
    end else if (strobe) begin
      if (cnt_nxt == size_q) begin
        req   <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen #(
  parameter int DEPTH = uart_dma_pkg::FIFO_DEPTH,
  parameter int THRW  = uart_dma_pkg::FIELD_W,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dma_en,
  input  logic [CW-1:0]   rx_level,
  input  logic            rx_pop,
  input  logic            rx_fine,
  input  logic [1:0]      rx_sel,
  input  logic [3:0]      rx_hi,
  input  logic [CW-1:0]   tx_level,
  input  logic            tx_push,
  input  logic            tx_fine,
  input  logic [1:0]      tx_sel,
  input  logic [3:0]      tx_hi,
  input  logic            tx_thr_mode,
  input  logic [THRW-1:0] tx_thr,
  output logic            rx_req,
  output logic            tx_req
);
  localparam int SW = CW + 1;
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
  localparam logic [SW-1:0] DEPTH_SW = SW'(DEPTH);

  logic [CW-1:0] rx_burst, tx_burst;
  logic [CW-1:0] tx_free, thr_ext;
  logic [SW-1:0] thr_sum;
  logic          thr_fits, use_thr, rx_start, tx_start;

  uart_dma_trig_dec #(.CW(CW)) u_rx_dec (
    .fine(rx_fine), .sel(rx_sel), .hi(rx_hi), .burst(rx_burst));

  uart_dma_trig_dec #(.CW(CW)) u_tx_dec (
    .fine(tx_fine), .sel(tx_sel), .hi(tx_hi), .burst(tx_burst));

  always_comb begin
    thr_ext  = {{(CW-THRW){1'b0}}, tx_thr};
    tx_free  = DEPTH_C - tx_level;
    thr_sum  = {1'b0, thr_ext} + {1'b0, tx_burst};
    thr_fits = (thr_sum <= DEPTH_SW);
    use_thr  = tx_thr_mode && thr_fits;
    rx_start = (rx_level >= rx_burst);
    tx_start = use_thr ? (tx_level <= thr_ext) : (tx_free >= tx_burst);
  end

  uart_dma_burst #(.CW(CW)) u_rx_burst (
    .clk(clk), .rst(rst), .en(dma_en), .start(rx_start),
    .strobe(rx_pop), .size(rx_burst), .req(rx_req));

  uart_dma_burst #(.CW(CW)) u_tx_burst (
    .clk(clk), .rst(rst), .en(dma_en), .start(tx_start),
    .strobe(tx_push), .size(tx_burst), .req(tx_req));
endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_en,
  input logic [CW-1:0] rx_level,
  input logic          rx_pop,
  input logic [CW-1:0] tx_level,
  input logic          tx_push,
  input logic          rx_req,
  input logic          tx_req
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rx_req && !tx_req));

  p_rx_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_req) |-> ($past(rx_level) != '0 && $past(dma_en)));

  p_rx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_req && dma_en && !rx_pop) |=> rx_req);

  p_tx_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> ($past(tx_level) < DEPTH_C || $past(tx_level) <= 7'd63));

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_req && dma_en && !tx_push) |=> tx_req);

  p_enable_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> (!rx_req && !tx_req));
endmodule

bind uart_dma_req_gen uart_dma_req_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .dma_en(dma_en),
  .rx_level(rx_level), .rx_pop(rx_pop),
  .tx_level(tx_level), .tx_push(tx_push),
  .rx_req(rx_req), .tx_req(tx_req));

// File: tb/tb_uart_dma_req_gen.sv
`timescale 1ns/1ps
module tb_uart_dma_req_gen;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dma_en = 1'b0;
  logic [6:0] rx_level = '0;
  logic       rx_pop = 1'b0;
  logic       rx_fine = 1'b0;
  logic [1:0] rx_sel = '0;
  logic [3:0] rx_hi = '0;
  logic [6:0] tx_level = 7'd64;
  logic       tx_push = 1'b0;
  logic       tx_fine = 1'b0;
  logic [1:0] tx_sel = '0;
  logic [3:0] tx_hi = '0;
  logic       tx_thr_mode = 1'b0;
  logic [5:0] tx_thr = '0;
  logic       rx_req, tx_req;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_dma_req_gen dut (
    .clk(clk), .rst(rst), .dma_en(dma_en),
    .rx_level(rx_level), .rx_pop(rx_pop),
    .rx_fine(rx_fine), .rx_sel(rx_sel), .rx_hi(rx_hi),
    .tx_level(tx_level), .tx_push(tx_push),
    .tx_fine(tx_fine), .tx_sel(tx_sel), .tx_hi(tx_hi),
    .tx_thr_mode(tx_thr_mode), .tx_thr(tx_thr),
    .rx_req(rx_req), .tx_req(tx_req));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // R7 size arithmetic
  function automatic int exp_burst(input logic fine, input logic [1:0] sel,
                                   input logic [3:0] hi);
    int v;
    if (fine) begin
      v = {hi, sel};
      if (v == 0) v = 1;
    end else begin
      case (sel)
        2'd0: v = 8;
        2'd1: v = 16;
        2'd2: v = 32;
        default: v = 56;
      endcase
    end
    return v;
  endfunction

  // RX burst for size b: R2, R3, R4, R7
  task automatic rx_run(input int b);
    rx_level = 7'(b - 1);
    rx_pop = 1'b1;
    step();
    step();
    rx_pop = 1'b0;
    step();
    check(rx_req, 1'b0, "R2 rx below trigger / R4 idle pops");
    rx_level = 7'(b);
    step();
    check(rx_req, 1'b1, "R2 rx at trigger R7");
    rx_level = '0;
    rx_pop = 1'b1;
    for (int i = 0; i < b - 1; i++) step();
    check(rx_req, 1'b1, "R3 rx held before last pop R4");
    step();
    rx_pop = 1'b0;
    check(rx_req, 1'b0, "R3 rx released after burst R7");
  endtask

  // TX room-based burst for size b: R5, R6, R7
  task automatic tx_run(input int b);
    tx_level = 7'(DEPTH - b + 1);
    step();
    step();
    check(tx_req, 1'b0, "R5 tx room one short");
    tx_level = 7'(DEPTH - b);
    step();
    check(tx_req, 1'b1, "R5 tx room enough R7");
    tx_level = 7'(DEPTH);
    tx_push = 1'b1;
    for (int i = 0; i < b - 1; i++) step();
    tx_push = 1'b0;
    step();
    check(tx_req, 1'b1, "R6 tx held after short write");
    tx_push = 1'b1;
    step();
    tx_push = 1'b0;
    check(tx_req, 1'b0, "R6 tx released after burst R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset holds requests low even with triggering levels
    dma_en = 1'b1;
    rx_level = 7'd64;
    tx_level = 7'd0;
    step();
    step();
    check(rx_req, 1'b0, "R1 rx low in reset");
    check(tx_req, 1'b0, "R1 tx low in reset");
    rx_level = '0;
    tx_level = 7'd64;
    rst = 1'b0;
    step();

    // Sweep presets and all fine encodings
    for (int f = 0; f < 2; f++) begin
      for (int h = 0; h < (f == 1 ? 16 : 1); h++) begin
        for (int s = 0; s < 4; s++) begin
          int b;
          rx_fine = f[0]; rx_hi = 4'(h); rx_sel = 2'(s);
          tx_fine = f[0]; tx_hi = 4'(h); tx_sel = 2'(s);
          b = exp_burst(f[0], 2'(s), 4'(h));
          rx_run(b);
          tx_run(b);
        end
      end
    end

    // R5: empty FIFO with the largest preset
    tx_fine = 1'b0; tx_sel = 2'd3;
    tx_level = 7'd0;
    step();
    check(tx_req, 1'b1, "R5 tx empty fifo");
    dma_en = 1'b0;
    tx_level = 7'd64;
    step();
    check(tx_req, 1'b0, "R10 tx gated by enable");
    dma_en = 1'b1;

    // R8 / R9: threshold sweep with burst 8
    tx_fine = 1'b1; tx_hi = 4'd2; tx_sel = 2'd0;
    tx_thr_mode = 1'b1;
    for (int t = 0; t < 64; t++) begin
      logic eff;
      logic e1;
      logic e2;
      eff = (t + 8 <= DEPTH);
      e1 = eff ? 1'b0 : ((DEPTH - (t + 1)) >= 8);
      e2 = eff ? 1'b1 : ((DEPTH - t) >= 8);
      dma_en = 1'b0;
      step();
      tx_thr = 6'(t);
      tx_level = 7'(t + 1);
      dma_en = 1'b1;
      step();
      check(tx_req, e1, eff ? "R8 thr above level" : "R9 fallback above");
      tx_level = 7'(t);
      step();
      check(tx_req, e2, eff ? "R8 thr at level" : "R9 fallback at level");
    end

    // R8: threshold 3, burst 8 full sequence
    dma_en = 1'b0;
    step();
    tx_thr = 6'd3;
    tx_level = 7'd4;
    dma_en = 1'b1;
    step();
    check(tx_req, 1'b0, "R8 thr3 level4 no req");
    tx_level = 7'd3;
    step();
    check(tx_req, 1'b1, "R8 thr3 level3 req");
    tx_level = 7'd11;
    tx_push = 1'b1;
    for (int i = 0; i < 7; i++) step();
    check(tx_req, 1'b1, "R8 held before 8th push");
    step();
    tx_push = 1'b0;
    check(tx_req, 1'b0, "R8 released after 8 pushes");
    step();
    check(tx_req, 1'b0, "R8 no refill above thr");
    tx_thr_mode = 1'b0;
    tx_level = 7'd64;

    // R10: enable drop mid-burst discards count
    rx_fine = 1'b0; rx_sel = 2'd0;
    rx_level = 7'd8;
    step();
    check(rx_req, 1'b1, "R10 rx asserted");
    rx_pop = 1'b1;
    repeat (3) step();
    rx_pop = 1'b0;
    dma_en = 1'b0;
    step();
    check(rx_req, 1'b0, "R10 rx dropped by enable");
    dma_en = 1'b1;
    step();
    check(rx_req, 1'b1, "R10 rx reasserted");
    rx_level = '0;
    rx_pop = 1'b1;
    repeat (7) step();
    check(rx_req, 1'b1, "R10 full burst needed again");
    step();
    rx_pop = 1'b0;
    check(rx_req, 1'b0, "R10 released after full burst");

    // R11: size change mid-burst
    rx_level = 7'd8;
    step();
    check(rx_req, 1'b1, "R11 rx asserted size 8");
    rx_sel = 2'd3;
    rx_level = '0;
    rx_pop = 1'b1;
    repeat (7) step();
    check(rx_req, 1'b1, "R11 held at 7 pops");
    step();
    rx_pop = 1'b0;
    check(rx_req, 1'b0, "R11 released at captured size");

    // R1: reset mid-burst
    rx_level = 7'd56;
    step();
    check(rx_req, 1'b1, "R1 pre-reset assert");
    rst = 1'b1;
    step();
    check(rx_req, 1'b0, "R1 reset clears request");
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule